// File: doc/BRIEF.md
# Multi-Window Trigger Capture Buffer

This block records a stream of probe samples into one on-chip memory whose total depth is fixed at build time. At the start of a capture the memory is split into a power-of-two number of equal windows. Each window records one occurrence of a trigger pulse. A runtime trigger position P sets how many samples from before the trigger each window keeps. Before the trigger arrives, the active window is written as a ring, so the most recent history is always held. Once a trigger is accepted, the block stores the remaining samples that follow it. It then moves on to the next window and waits for a fresh trigger. When every window is full it raises a done flag and freezes the memory.

A host reads the result through a one-cycle-latency port addressed by window number and sample index. The rotation of each ring is undone on the way out, so index 0 is always the oldest sample in the window and the trigger sample always sits at index P. A start pulse latches a new configuration, clears done and arms window 0 again. The trigger source and the host link sit outside this block.

Top module: `capture_window_buffer`

## Requirements
- R1: After reset, done is low and no sample is stored. Sample and trigger traffic before the first start pulse leaves done low.
- R2: A start pulse latches winLog2, clamped to MAX_WIN_LOG2. The capture uses 2^winLog2 windows, each TOTAL_DEPTH >> winLog2 samples deep. done rises on the clock edge that stores the last sample of the last window, and not before.
- R3: With trigger position P, window indices 0..P-1 read back the P enabled samples that came just before the accepted trigger sample, in order. The trigger sample reads back at index P. The samples that follow it read back at indices P+1 and up.
- R4: With P = 0, the trigger sample is index 0 of its window, and the depth-1 enabled samples after it complete the window.
- R5: With P = depth-1, the trigger sample is the last index of its window, and the window closes on the trigger cycle itself.
- R6: A trigger is accepted only on a cycle with sampleEn high, and only after at least P samples have been stored since that window was armed. A trigger that arrives earlier is ignored, and its sample is stored as ordinary history.
- R7: After a window closes, the next window arms at once with its history count cleared. Each window therefore holds a separate trigger occurrence.
- R8: A cycle with sampleEn low stores nothing, advances nothing and accepts no trigger.
- R9: While done is high, samples and triggers do not change the memory, and done stays high until the next start pulse. done is low in the cycle after start.
- R10: rdData returns the sample at (rdWin, rdIdx) one clock after those inputs are presented. rdIdx is counted from the oldest sample of the window.
- R11: Bits of trigPos at or above the window depth are ignored. The position used is trigPos modulo the window depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch configuration, clear done, arm window 0 |
| winLog2 | input | LW_W | log2 of the window count, sampled at start |
| trigPos | input | ADDR_W | Trigger position within a window, sampled at start |
| sampleEn | input | 1 | Sample valid this cycle |
| sampleIn | input | DATA_W | Probe sample |
| trigIn | input | 1 | Trigger pulse, qualified by sampleEn |
| rdWin | input | WIN_W | Readout window number |
| rdIdx | input | ADDR_W | Readout index from the oldest sample |
| done | output | 1 | All windows filled |
| rdData | output | DATA_W | Readout sample, one cycle after the address |

## Verification
The bench uses the defaults TOTAL_DEPTH = 64, MAX_WIN_LOG2 = 3 and DATA_W = 16. Every window count from 1 window of 64 samples to 8 windows of 8 samples can therefore be tried within a few hundred cycles. The small 8-deep windows bring both position extremes into reach, along with frequent ring wrap-around. Dense trigger streams reach the early-trigger rejection and the re-arm between windows. A 16-bit sample counter makes every stored value unique, so any error in rotation or in window placement appears as a wrong readback.

// File: rtl/capwin_pkg.sv
package capwin_pkg;
  typedef struct packed {
    logic arm;        // configuration latched, window 0 armed
    logic wrEn;       // store sampleIn at the write address
    logic saveStart;  // record the oldest offset of the current window
  } strobe_t;
endpackage

// File: rtl/capwin_ctrl.sv
module capwin_ctrl
  import capwin_pkg::*;
#(
  parameter int TOTAL_DEPTH  = 64,
  parameter int MAX_WIN_LOG2 = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [$clog2(MAX_WIN_LOG2+1)-1:0] winLog2,
  input  logic [$clog2(TOTAL_DEPTH)-1:0]    trigPos,
  input  logic sampleEn,
  input  logic trigIn,
  output strobe_t strb,
  output logic [$clog2(TOTAL_DEPTH)-1:0]    wrAddr,
  output logic [$clog2(TOTAL_DEPTH)-1:0]    startOff,
  output logic [MAX_WIN_LOG2-1:0]           winIdx,
  output logic [$clog2(MAX_WIN_LOG2+1)-1:0] cfgLw,
  output logic done
);
  localparam int ADDR_W = $clog2(TOTAL_DEPTH);
  localparam int WIN_W  = MAX_WIN_LOG2;
  localparam int LW_W   = $clog2(MAX_WIN_LOG2+1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_POST, S_DONE} state_t;

  state_t state;
  logic [ADDR_W-1:0] cfgPos, wrPtr, preCnt, postLeft, mask, maskNew;
  logic [LW_W-1:0]   lwNew;
  logic [WIN_W-1:0]  lastWin;
  logic writeNow, trigHit, closeNow;

  always_comb begin
    lwNew   = (int'(winLog2) > MAX_WIN_LOG2) ? LW_W'(MAX_WIN_LOG2) : winLog2;
    maskNew = ADDR_W'((TOTAL_DEPTH - 1) >> lwNew);
    mask    = ADDR_W'((TOTAL_DEPTH - 1) >> cfgLw);
    lastWin = WIN_W'((1 << cfgLw) - 1);
    writeNow = sampleEn && !start && (state == S_PRE || state == S_POST);
    trigHit  = writeNow && state == S_PRE && trigIn && (preCnt >= cfgPos);
    closeNow = (trigHit && cfgPos == mask) ||
               (writeNow && state == S_POST && postLeft == ADDR_W'(1));
    wrAddr   = (ADDR_W'(winIdx) << (ADDR_W - int'(cfgLw))) | (wrPtr & mask);
    startOff = (wrPtr - cfgPos) & mask;
    strb.arm       = start;
    strb.wrEn      = writeNow;
    strb.saveStart = trigHit;
    done = (state == S_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cfgLw    <= '0;
      cfgPos   <= '0;
      wrPtr    <= '0;
      preCnt   <= '0;
      postLeft <= '0;
      winIdx   <= '0;
    end else if (start) begin
      state    <= S_PRE;
      cfgLw    <= lwNew;
      cfgPos   <= trigPos & maskNew;
      wrPtr    <= '0;
      preCnt   <= '0;
      postLeft <= '0;
      winIdx   <= '0;
    end else if (writeNow) begin
      wrPtr <= (wrPtr + ADDR_W'(1)) & mask;
      if (state == S_PRE && preCnt < cfgPos) preCnt <= preCnt + ADDR_W'(1);
      if (state == S_POST) postLeft <= postLeft - ADDR_W'(1);
      if (trigHit && !closeNow) begin
        state    <= S_POST;
        postLeft <= mask - cfgPos;
      end
      if (closeNow) begin
        if (winIdx == lastWin) begin
          state <= S_DONE;
        end else begin
          state  <= S_PRE;
          winIdx <= winIdx + WIN_W'(1);
          wrPtr  <= '0;
          preCnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/capwin_dpath.sv
module capwin_dpath
  import capwin_pkg::*;
#(
  parameter int TOTAL_DEPTH  = 64,
  parameter int MAX_WIN_LOG2 = 3,
  parameter int DATA_W       = 16
) (
  input  logic clk,
  input  logic rstN,
  input  strobe_t strb,
  input  logic [$clog2(TOTAL_DEPTH)-1:0]    wrAddr,
  input  logic [$clog2(TOTAL_DEPTH)-1:0]    startOff,
  input  logic [MAX_WIN_LOG2-1:0]           winIdx,
  input  logic [$clog2(MAX_WIN_LOG2+1)-1:0] cfgLw,
  input  logic [DATA_W-1:0]                 sampleIn,
  input  logic [MAX_WIN_LOG2-1:0]           rdWin,
  input  logic [$clog2(TOTAL_DEPTH)-1:0]    rdIdx,
  output logic [DATA_W-1:0]                 rdData
);
  localparam int ADDR_W  = $clog2(TOTAL_DEPTH);
  localparam int NUM_WIN = 1 << MAX_WIN_LOG2;

  logic [DATA_W-1:0] mem [TOTAL_DEPTH];
  logic [ADDR_W-1:0] oldest [NUM_WIN];
  logic [ADDR_W-1:0] rdMask, rdAddr;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WIN; i++) oldest[i] <= '0;
    end else if (strb.saveStart) begin
      oldest[winIdx] <= startOff;
    end
  end

  always_comb begin
    rdMask = ADDR_W'((TOTAL_DEPTH - 1) >> cfgLw);
    rdAddr = (ADDR_W'(rdWin) << (ADDR_W - int'(cfgLw))) |
             ((oldest[rdWin] + rdIdx) & rdMask);
  end

  always_ff @(posedge clk) rdData <= mem[rdAddr];
endmodule

// File: rtl/capture_window_buffer.sv
module capture_window_buffer
  import capwin_pkg::*;
#(
  parameter int TOTAL_DEPTH  = 64,
  parameter int MAX_WIN_LOG2 = 3,
  parameter int DATA_W       = 16,
  localparam int ADDR_W = $clog2(TOTAL_DEPTH),
  localparam int WIN_W  = MAX_WIN_LOG2,
  localparam int LW_W   = $clog2(MAX_WIN_LOG2+1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LW_W-1:0]   winLog2,
  input  logic [ADDR_W-1:0] trigPos,
  input  logic              sampleEn,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              trigIn,
  input  logic [WIN_W-1:0]  rdWin,
  input  logic [ADDR_W-1:0] rdIdx,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);
  strobe_t           strb;
  logic [ADDR_W-1:0] wrAddr, startOff;
  logic [WIN_W-1:0]  winIdx;
  logic [LW_W-1:0]   cfgLw;

  capwin_ctrl #(.TOTAL_DEPTH(TOTAL_DEPTH), .MAX_WIN_LOG2(MAX_WIN_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .winLog2(winLog2), .trigPos(trigPos),
    .sampleEn(sampleEn), .trigIn(trigIn), .strb(strb), .wrAddr(wrAddr),
    .startOff(startOff), .winIdx(winIdx), .cfgLw(cfgLw), .done(done)
  );

  capwin_dpath #(.TOTAL_DEPTH(TOTAL_DEPTH), .MAX_WIN_LOG2(MAX_WIN_LOG2), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .startOff(startOff),
    .winIdx(winIdx), .cfgLw(cfgLw), .sampleIn(sampleIn), .rdWin(rdWin),
    .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: rtl/capwin_checks.sv
module capwin_checks
  import capwin_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    start,
  input logic    sampleEn,
  input logic    trigIn,
  input logic    done,
  input strobe_t strb
);
  p_write_needs_sample_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> sampleEn);

  p_trigger_qualified_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.saveStart |-> (trigIn && sampleEn && strb.wrEn));

  p_frozen_when_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strb.wrEn);

  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  p_start_clears_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done);

  p_no_write_on_arm_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.arm |-> !strb.wrEn);
endmodule

bind capture_window_buffer capwin_checks u_checks (
  .clk(clk), .rstN(rstN), .start(start), .sampleEn(sampleEn),
  .trigIn(trigIn), .done(done), .strb(strb)
);

// File: tb/capture_window_buffer_test.sv
`timescale 1ns/1ps
module capture_window_buffer_test;
  localparam int TD = 64;
  localparam int MW = 3;
  localparam int DW = 16;

  logic clk = 0, rstN = 0, start = 0, sampleEn = 0, trigIn = 0;
  logic [1:0]  winLog2 = '0;
  logic [5:0]  trigPos = '0;
  logic [DW-1:0] sampleIn = '0;
  logic [2:0]  rdWin = '0;
  logic [5:0]  rdIdx = '0;
  logic done;
  logic [DW-1:0] rdData;

  int tests = 0, fails = 0;
  logic [DW-1:0] seqVal = 16'h0100;
  logic [DW-1:0] ring [64];
  logic [DW-1:0] expd [8][64];

  capture_window_buffer uut (
    .clk(clk), .rstN(rstN), .start(start), .winLog2(winLog2), .trigPos(trigPos),
    .sampleEn(sampleEn), .sampleIn(sampleIn), .trigIn(trigIn), .rdWin(rdWin),
    .rdIdx(rdIdx), .done(done), .rdData(rdData)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_all(input int nWin, input int depth, input string req);
    for (int w = 0; w < nWin; w++)
      for (int i = 0; i < depth; i++) begin
        @(negedge clk);
        rdWin = 3'(w); rdIdx = 6'(i);
        @(negedge clk);
        check(rdData === expd[w][i], $sformatf("%s R10 win%0d idx%0d", req, w, i),
              int'(rdData), int'(expd[w][i]));
      end
  endtask

  // Drive a full capture and build the expected windows from the requirements.
  task automatic run_capture(input int lw, input int posIn, input int enPct,
                             input int trigPct, input string req);
    int depth, nWin, pos, win, histN, postIdx, cyc;
    bit inPost, finished, en, tr;
    depth = TD >> lw; nWin = 1 << lw; pos = posIn & (depth - 1);
    win = 0; histN = 0; postIdx = 0; cyc = 0; inPost = 0; finished = 0;
    @(negedge clk);
    start = 1; winLog2 = 2'(lw); trigPos = 6'(posIn); sampleEn = 0; trigIn = 0;
    @(negedge clk);
    start = 0;
    check(done == 0, {req, " R9 start clears done"}, int'(done), 0);
    while (!finished && cyc < 20000) begin
      en = ($urandom % 100) < enPct;
      tr = ($urandom % 100) < trigPct;
      sampleEn = en; trigIn = tr; sampleIn = seqVal;
      if (en) begin
        if (!inPost) begin
          if (tr && histN >= pos) begin
            for (int k = 0; k < pos; k++) expd[win][k] = ring[(histN - pos + k) % 64];
            expd[win][pos] = seqVal;
            postIdx = pos + 1;
            inPost = (postIdx < depth);
          end else begin
            ring[histN % 64] = seqVal;
            histN++;
          end
        end else begin
          expd[win][postIdx] = seqVal;
          postIdx++;
          inPost = (postIdx < depth);
        end
        if (postIdx == depth) begin
          postIdx = 0; histN = 0; win++;
          if (win == nWin) begin
            finished = 1;
            check(done == 0, {req, " R2 done not before last sample"}, int'(done), 0);
          end
        end
      end
      seqVal++; cyc++;
      @(negedge clk);
    end
    sampleEn = 0; trigIn = 0;
    check(done == 1, {req, " R2 done after last window"}, int'(done), 1);
    read_all(nWin, depth, req);
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(done == 0, "R1 reset done low", int'(done), 0);
    rstN = 1;
    // R1: traffic before any start
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      sampleEn = 1; trigIn = (i % 3 == 0); sampleIn = 16'(i);
    end
    @(negedge clk); sampleEn = 0; trigIn = 0;
    check(done == 0, "R1 idle before start", int'(done), 0);

    run_capture(0, 0, 100, 20, "R4 pos0 single");
    run_capture(2, 15, 100, 25, "R5 last position");
    run_capture(1, 10, 70, 30, "R3 R6 R8 gaps");
    run_capture(3, 3, 50, 100, "R6 R7 dense triggers");
    run_capture(3, 7, 60, 100, "R5 R7 small windows");
    run_capture(2, 5 + 16, 80, 30, "R11 high bits");

    // R9: frozen after done; window 0 of last capture still intact
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sampleEn = 1; trigIn = 1; sampleIn = 16'hdead;
    end
    @(negedge clk); sampleEn = 0; trigIn = 0;
    check(done == 1, "R9 done holds", int'(done), 1);
    read_all(1, 16, "R9 frozen");

    for (int r = 0; r < 5; r++)
      run_capture(int'($urandom % 4), int'($urandom % 64), 40 + int'($urandom % 60),
                  5 + int'($urandom % 60), "R3 R7 random");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule